// File: doc/BRIEF.md
# Static Register-Form Instruction Translator

This block rewrites a stream of two-byte source instructions into 32-bit target data-processing words before any of the translated code runs. Each source instruction is an opcode byte followed by a register-select byte (a 2-bit mode field, a 3-bit `reg` field and a 3-bit `rm` field). It arrives with the address it was fetched from. The block emits one target word per source instruction, each paired with the destination address where it is to be stored. Both sides of the block are valid/ready streams, and each side is buffered by a small FIFO that keeps the instruction and its address together. A stall on the fetch side or the store side therefore costs cycles but loses no data.

Inside, a finite state machine groups instructions by addressing mode rather than by operation. All register-to-register arithmetic and logic forms share one state, and a small opcode map inside that state picks the target operation code. Register moves have their own state, which leaves the first operand field empty. Anything the block does not understand goes to a third state. That state emits a no-op word, so the output count still matches the input count, and raises a sticky error flag. A `start` pulse loads the destination base address and clears the error.

Stream rules: an input beat is taken on a rising edge where `in_valid` and `in_ready` are both high. An output beat is taken on a rising edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_word` and `out_addr` hold steady. `in_ready` falls only when the input FIFO is full. `start` is meant to be pulsed while no instruction is in flight.

Top module: `insn_xlat_top`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `err_flag` is 0.
- R2: A source instruction with mode field 2'b11 and opcode 0x01, 0x29, 0x21, 0x09 or 0x31 produces a word in one of five forms:
  - 0x01 gives operation code 4'h4.
  - 0x29 gives operation code 4'h2.
  - 0x21 gives operation code 4'h0.
  - 0x09 gives operation code 4'hC.
  - 0x31 gives operation code 4'h1.
  - The word is {4'hE, 3'b000, op[3:0], 1'b0, rn, rd, 8'h00, rm} with rn = rd = the `rm` field and rm = the `reg` field.
  - Field positions in the source instruction: opcode is in bits [15:8], mode in [7:6], `reg` in [5:3] and `rm` in [2:0].
- R3: Opcode 0x89 with mode 2'b11 produces 32'hE1A00000 | (`rm` << 12) | `reg`.
- R4: Source register index n (0 to 7) becomes target register n, with bit 3 of every 4-bit register field always 0.
- R5: An opcode outside the six above produces the no-op word 32'hE1A00000 and sets `err_flag`. `err_addr` then holds the source address of the first offending instruction since the last `start`.
- R6: A supported opcode with a mode field other than 2'b11 is handled as in R5.
- R7: `err_flag` and `err_addr` stay set until a `start` pulse, which clears both.
- R8: The first word after `start` carries `out_addr` = `dst_base`, and each later word carries the previous address plus 4.
- R9: Exactly one output word is produced per input instruction, in input order, with the destination addresses in step.
- R10: Back-pressure.
  - While the output is stalled, `out_word` and `out_addr` hold steady.
  - With the default depths of 4 and the output stalled from empty, exactly 9 instructions are accepted before `in_ready` stays low.
  - All 9 are delivered intact once the stall ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse: load destination base, clear error |
| dst_base | input | ADDR_W | Destination address of the first word after `start` |
| in_valid | input | 1 | Source instruction beat is valid |
| in_ready | output | 1 | Block can take a source beat |
| in_insn | input | 16 | Source instruction: opcode [15:8], register-select byte [7:0] |
| in_addr | input | ADDR_W | Source address of the instruction |
| out_valid | output | 1 | Translated word is valid |
| out_ready | input | 1 | Consumer takes the translated word |
| out_word | output | 32 | Translated target word |
| out_addr | output | ADDR_W | Destination address of the word |
| err_flag | output | 1 | Sticky: an untranslatable instruction was seen |
| err_addr | output | ADDR_W | Source address of the first untranslatable instruction |

## Verification
The bench aims at the opcode map inside the shared arithmetic state. A swapped or mistyped entry would give a sibling operation its code, and a field swap would exchange the destination and source registers. It sends an unsupported opcode and a memory-mode form of a supported opcode: a design that mishandled them would drop the instruction and shift every later address, or would report the second failure's address instead of the first. It stalls the output until the input side refuses data, then counts what was accepted and drains it. A FIFO with a wrong full test or a lost handover between the decoder and a FIFO would deliver fewer words, or words out of order.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int SRC_W  = 16;
  localparam int WORD_W = 32;

  // Supported source opcodes
  localparam logic [7:0] SRC_ADD = 8'h01;
  localparam logic [7:0] SRC_SUB = 8'h29;
  localparam logic [7:0] SRC_AND = 8'h21;
  localparam logic [7:0] SRC_OR  = 8'h09;
  localparam logic [7:0] SRC_XOR = 8'h31;
  localparam logic [7:0] SRC_MOV = 8'h89;

  localparam logic [1:0] MODE_REG    = 2'b11;
  localparam logic [3:0] COND_ALWAYS = 4'hE;
  localparam logic [WORD_W-1:0] WORD_NOP = 32'hE1A00000;

  typedef enum logic [3:0] {
    DP_AND = 4'h0,
    DP_EOR = 4'h1,
    DP_SUB = 4'h2,
    DP_ADD = 4'h4,
    DP_ORR = 4'hC,
    DP_MOV = 4'hD
  } dp_op_e;

  // States are grouped by addressing mode, not by operation
  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_ALU_RR = 2'd1,
    ST_MOV_RR = 2'd2,
    ST_BAD    = 2'd3
  } xlat_state_e;

  typedef struct packed {
    logic [7:0] opcode;
    logic [1:0] mode;
    logic [2:0] reg_f;
    logic [2:0] rm_f;
  } src_insn_t;

  function automatic logic [WORD_W-1:0] dp_word(dp_op_e op, logic [3:0] rn,
                                                logic [3:0] rd, logic [3:0] rm);
    return {COND_ALWAYS, 2'b00, 1'b0, op, 1'b0, rn, rd, 8'h00, rm};
  endfunction

  function automatic logic [3:0] widen_reg(logic [2:0] r);
    return {1'b0, r};
  endfunction

endpackage

// File: rtl/xlat_pair_fifo.sv
module xlat_pair_fifo #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [ADDR_W-1:0] head_addr,
  output logic              full,
  output logic              empty
);
  // DEPTH must be a power of two
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [PTR_W:0]    wr_ptr, rd_ptr;
  logic [PTR_W-1:0]  wr_idx, rd_idx;

  assign wr_idx = wr_ptr[PTR_W-1:0];
  assign rd_idx = rd_ptr[PTR_W-1:0];
  assign empty  = (wr_ptr == rd_ptr);
  assign full   = (wr_ptr[PTR_W] != rd_ptr[PTR_W]) && (wr_idx == rd_idx);

  assign head_data = data_mem[rd_idx];
  assign head_addr = addr_mem[rd_idx];

  // Instruction and address are written together into their two memories
  always_ff @(posedge clk) begin
    if (push) begin
      data_mem[wr_idx] <= push_data;
      addr_mem[wr_idx] <= push_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full)
    else $error("push into full pair fifo");

  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty)
    else $error("pop from empty pair fifo");

endmodule

// File: rtl/xlat_classify.sv
module xlat_classify
  import xlat_pkg::*;
(
  input  src_insn_t   insn,
  output xlat_state_e cls
);
  always_comb begin
    if (insn.mode != MODE_REG) begin
      cls = ST_BAD;
    end else begin
      unique case (insn.opcode)
        SRC_ADD, SRC_SUB, SRC_AND, SRC_OR, SRC_XOR: cls = ST_ALU_RR;
        SRC_MOV:                                    cls = ST_MOV_RR;
        default:                                    cls = ST_BAD;
      endcase
    end
  end
endmodule

// File: rtl/xlat_decoder.sv
module xlat_decoder
  import xlat_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic              in_empty,
  input  logic [SRC_W-1:0]  in_insn,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              in_pop,
  input  logic              out_full,
  output logic              out_push,
  output logic [WORD_W-1:0] out_word,
  output logic [ADDR_W-1:0] out_addr,
  output logic              err_flag,
  output logic [ADDR_W-1:0] err_addr
);
  xlat_state_e       state, state_nx, head_cls;
  src_insn_t         cur;
  logic [ADDR_W-1:0] cur_src;
  logic [ADDR_W-1:0] dst_q;

  xlat_classify u_classify (
    .insn (src_insn_t'(in_insn)),
    .cls  (head_cls)
  );

  // Opcode map used only inside the shared register-arithmetic state
  function automatic dp_op_e alu_map(logic [7:0] opc);
    case (opc)
      SRC_ADD: return DP_ADD;
      SRC_SUB: return DP_SUB;
      SRC_OR:  return DP_ORR;
      SRC_XOR: return DP_EOR;
      default: return DP_AND;
    endcase
  endfunction

  always_comb begin
    state_nx = state;
    in_pop   = 1'b0;
    out_push = 1'b0;
    out_word = WORD_NOP;
    unique case (state)
      ST_FETCH: begin
        if (!in_empty) begin
          in_pop   = 1'b1;
          state_nx = head_cls;
        end
      end
      ST_ALU_RR: begin
        out_word = dp_word(alu_map(cur.opcode), widen_reg(cur.rm_f),
                           widen_reg(cur.rm_f), widen_reg(cur.reg_f));
        out_push = !out_full;
      end
      ST_MOV_RR: begin
        out_word = dp_word(DP_MOV, 4'h0, widen_reg(cur.rm_f), widen_reg(cur.reg_f));
        out_push = !out_full;
      end
      ST_BAD: begin
        out_word = WORD_NOP;
        out_push = !out_full;
      end
      default: state_nx = ST_FETCH;
    endcase
    if (out_push) state_nx = ST_FETCH;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_FETCH;
      cur      <= '0;
      cur_src  <= '0;
      dst_q    <= '0;
      err_flag <= 1'b0;
      err_addr <= '0;
    end else begin
      state <= state_nx;
      if (in_pop) begin
        cur     <= src_insn_t'(in_insn);
        cur_src <= in_addr;
      end
      if (start) begin
        dst_q    <= dst_base;
        err_flag <= 1'b0;
        err_addr <= '0;
      end else if (out_push) begin
        dst_q <= dst_q + ADDR_W'(4);
        if (state == ST_BAD && !err_flag) begin
          err_flag <= 1'b1;
          err_addr <= cur_src;
        end
      end
    end
  end

  assign out_addr = dst_q;

  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_push && !start) |=> (out_addr == $past(out_addr) + ADDR_W'(4)))
    else $error("destination address did not advance by 4");

  p_start_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (out_addr == $past(dst_base)) && !err_flag)
    else $error("start did not load base or clear error");

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !start) |=> (err_flag && $stable(err_addr)))
    else $error("error flag or address changed without start");

  p_push_not_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_pop |=> !in_pop)
    else $error("two instructions popped back to back");

endmodule

// File: rtl/insn_xlat_top.sv
module insn_xlat_top
  import xlat_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IN_DEPTH  = 4,
  parameter int OUT_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_insn,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_word,
  output logic [ADDR_W-1:0] out_addr,
  output logic              err_flag,
  output logic [ADDR_W-1:0] err_addr
);
  logic              in_full, in_empty, dec_pop;
  logic [SRC_W-1:0]  head_insn;
  logic [ADDR_W-1:0] head_addr;
  logic              out_full, out_empty, dec_push;
  logic [WORD_W-1:0] dec_word;
  logic [ADDR_W-1:0] dec_addr;

  assign in_ready  = !in_full;
  assign out_valid = !out_empty;

  xlat_pair_fifo #(.DATA_W(SRC_W), .ADDR_W(ADDR_W), .DEPTH(IN_DEPTH)) u_in_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (in_valid && in_ready),
    .push_data (in_insn),
    .push_addr (in_addr),
    .pop       (dec_pop),
    .head_data (head_insn),
    .head_addr (head_addr),
    .full      (in_full),
    .empty     (in_empty)
  );

  xlat_decoder #(.ADDR_W(ADDR_W)) u_decoder (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .dst_base (dst_base),
    .in_empty (in_empty),
    .in_insn  (head_insn),
    .in_addr  (head_addr),
    .in_pop   (dec_pop),
    .out_full (out_full),
    .out_push (dec_push),
    .out_word (dec_word),
    .out_addr (dec_addr),
    .err_flag (err_flag),
    .err_addr (err_addr)
  );

  xlat_pair_fifo #(.DATA_W(WORD_W), .ADDR_W(ADDR_W), .DEPTH(OUT_DEPTH)) u_out_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (dec_push),
    .push_data (dec_word),
    .push_addr (dec_addr),
    .pop       (out_valid && out_ready),
    .head_data (out_word),
    .head_addr (out_addr),
    .full      (out_full),
    .empty     (out_empty)
  );

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_addr)))
    else $error("output changed while stalled");

  p_cond_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_word[31:28] == COND_ALWAYS))
    else $error("condition field is not always-execute");

  p_reg_hi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_word[19] == 1'b0 && out_word[15] == 1'b0 && out_word[3] == 1'b0))
    else $error("register field bit 3 set");

endmodule

// File: tb/insn_xlat_top_bench.sv
module insn_xlat_top_bench;
  localparam int NV = 9;
  // {source instruction, expected word}
  localparam logic [47:0] VEC [NV] = '{
    {16'h01D8, 32'hE0800003},
    {16'h29CA, 32'hE0422001},
    {16'h21F7, 32'hE0077006},
    {16'h09E5, 32'hE1855004},
    {16'h31C0, 32'hE0200000},
    {16'h89D9, 32'hE1A01003},
    {16'h89FE, 32'hE1A06007},
    {16'h01FF, 32'hE0877007},
    {16'h31DE, 32'hE0266003}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dst_base = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_insn = '0;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_word, out_addr;
  logic        err_flag;
  logic [31:0] err_addr;

  int checks = 0;
  int fails  = 0;
  logic [31:0] got_word, got_addr;

  always #2.5 clk = ~clk;

  insn_xlat_top u_insn_xlat_top (
    .clk(clk), .rst_n(rst_n), .start(start), .dst_base(dst_base),
    .in_valid(in_valid), .in_ready(in_ready), .in_insn(in_insn), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .out_addr(out_addr),
    .err_flag(err_flag), .err_addr(err_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] insn, input logic [31:0] addr);
    @(negedge clk);
    in_valid = 1'b1; in_insn = insn; in_addr = addr;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic recv();
    @(negedge clk);
    out_ready = 1'b1;
    while (!out_valid) @(negedge clk);
    got_word = out_word;
    got_addr = out_addr;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic pulse_start(input logic [31:0] base);
    @(negedge clk);
    start = 1'b1; dst_base = base;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int accepted;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 in_ready", {31'd0, in_ready}, 32'd1);
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 err_flag", {31'd0, err_flag}, 32'd0);
    rst_n = 1'b1;
    pulse_start(32'h0000_1000);

    // Table walk: R2 arithmetic forms, R3 moves, R8 addresses
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][47:32], 32'h400 + 32'(i) * 4);
      recv();
      chk((VEC[i][47:40] == 8'h89) ? "R3 word" : "R2 word", got_word, VEC[i][31:0]);
      chk("R8 addr", got_addr, 32'h1000 + 32'(i) * 4);
      if (i == 7) chk("R4 high regs", got_word[19:0], 20'h77007);
    end
    chk("R5 no error on valid forms", {31'd0, err_flag}, 32'd0);

    // R5 unsupported opcode
    send(16'h8BC0, 32'h500);
    recv();
    chk("R5 nop", got_word, 32'hE1A00000);
    chk("R5 addr kept in step", got_addr, 32'h1024);
    chk("R5 err_flag", {31'd0, err_flag}, 32'd1);
    chk("R5 err_addr", err_addr, 32'h500);
    // R6 memory mode on a supported opcode
    send(16'h0118, 32'h504);
    recv();
    chk("R6 nop", got_word, 32'hE1A00000);
    chk("R6 addr", got_addr, 32'h1028);
    chk("R6 first error kept", err_addr, 32'h500);
    // R7 sticky through a good instruction
    send(16'h01D8, 32'h508);
    recv();
    chk("R7 good word after error", got_word, 32'hE0800003);
    chk("R7 sticky", {31'd0, err_flag}, 32'd1);
    pulse_start(32'h0000_2000);
    chk("R7 cleared by start", {31'd0, err_flag}, 32'd0);
    chk("R7 err_addr cleared", err_addr, 32'h0);

    // R10 stall output, fill everything
    accepted = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (in_ready) begin
        in_valid = 1'b1;
        in_insn  = VEC[accepted % NV][47:32];
        in_addr  = 32'h600 + 32'(accepted) * 4;
        accepted++;
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 accepted count", 32'(accepted), 32'd9);
    chk("R10 in_ready low", {31'd0, in_ready}, 32'd0);
    held = out_word;
    repeat (3) @(negedge clk);
    chk("R10 held valid", {31'd0, out_valid}, 32'd1);
    chk("R10 held word", out_word, held);
    // R9 drain in order
    for (int j = 0; j < accepted; j++) begin
      recv();
      chk("R9 order word", got_word, VEC[j % NV][31:0]);
      chk("R9 order addr", got_addr, 32'h2000 + 32'(j) * 4);
    end
    repeat (3) @(negedge clk);
    chk("R9 no extra output", {31'd0, out_valid}, 32'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule